// File: doc/BRIEF.md
# Half-Word to Word Register Bridge

This block lets a 16-bit request bus reach a bank of 32-bit registers. Each 32-bit register is seen upstream as two half-words at byte offsets 0 and 2 of its word. A write to the lower half is kept in a holding register and goes no further. A write to the upper half then commits one full 32-bit downstream write, made of the new upper value and the held lower value.

Reads run the other way. A lower-half read performs one downstream 32-bit read. It returns the low 16 bits and keeps the high 16 bits in a latch. A following upper-half read returns that latch and does not touch the register bank. Software that reads or writes the lower half first therefore moves all 32 bits as one atomic access, even if the register changes between the two half-word accesses.

The downstream side is a single-cycle register port: the strobe, address and write data are driven in the request cycle, and read data comes back combinationally in that same cycle. Upstream, every request gets a one-cycle response pulse in the following cycle. 8-bit requests are refused with an error pulse.

Top module: `hw_word_bridge`

## Requirements
- R1: After reset the lower-half holding register and the upper-half read latch are zero. `ack_o`, `err_o` and `rdata_o` are 0, and no downstream strobe is active.
- R2: A half-word write (`byte_i`=0) with address bit 1 = 0 stores `wdata_i` in the holding register. It asserts neither `reg_we_o` nor `reg_re_o`.
- R3: A half-word write with address bit 1 = 1 asserts `reg_we_o` for that one cycle. It drives `reg_wdata_o` = {`wdata_i`, held lower value} and `reg_addr_o` = `addr_i` with bits 1:0 cleared.
- R4: A half-word read with address bit 1 = 0 asserts `reg_re_o` in the request cycle, with `reg_addr_o` = `addr_i` with bits 1:0 cleared. In the next cycle `rdata_o` shows `reg_rdata_i[15:0]` as sampled in the request cycle.
- R5: A half-word read with address bit 1 = 1 makes no downstream access. In the next cycle `rdata_o` shows the upper-half latch.
- R6: An 8-bit request (`byte_i`=1) makes no downstream access and leaves both the holding register and the latch unchanged. It gives `err_o`=1 and `ack_o`=0 in the next cycle only.
- R7: The held lower value stays in place across upper-half writes, reads and refused requests. It is reused by every upper-half write until the next lower-half write.
- R8: The upper-half latch changes only on a lower-half read, where it takes `reg_rdata_i[31:16]`. Writes do not alter it.
- R9: Every accepted half-word request gives `ack_o`=1 for exactly the following cycle with `err_o`=0. `rdata_o` changes only on reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Request valid this cycle |
| we_i | input | 1 | 1 = write, 0 = read |
| byte_i | input | 1 | 1 = 8-bit request (refused), 0 = half-word |
| addr_i | input | AW | Byte address; bit 1 selects the upper half |
| wdata_i | input | HW | Half-word write data |
| rdata_o | output | HW | Half-word read data, valid with ack_o |
| ack_o | output | 1 | Accepted-request response pulse |
| err_o | output | 1 | Refused-request response pulse |
| reg_we_o | output | 1 | Downstream 32-bit write strobe |
| reg_re_o | output | 1 | Downstream 32-bit read strobe |
| reg_addr_o | output | AW | Downstream word address |
| reg_wdata_o | output | 2*HW | Downstream write data |
| reg_rdata_i | input | 2*HW | Downstream read data, same cycle |

## Verification
The bench drives the bridge with back-to-back mixes of lower and upper half writes and reads, across two register words, in front of a small register-bank model.

- Pairs of upper writes after a single lower write show whether the held half is reused rather than cleared.
- An upper read placed after an intervening upper write shows whether the read latch is disturbed by writes.
- Refused 8-bit requests are placed between a lower write and its upper commit, so corruption of the held half shows up in the committed word. A refused request is followed at once by a good one, which shows that the error is a single-cycle pulse.
- A reset applied between a lower write and its upper commit shows that the holding register clears.

// File: rtl/hw_bridge_pkg.sv
package hw_bridge_pkg;
  typedef enum logic [2:0] {
    ACC_IDLE,
    ACC_WR_LO,
    ACC_WR_HI,
    ACC_RD_LO,
    ACC_RD_HI,
    ACC_BAD
  } acc_e;
endpackage

// File: rtl/hwb_decode.sv
module hwb_decode
  import hw_bridge_pkg::*;
(
  input  logic req_i,
  input  logic we_i,
  input  logic byte_i,
  input  logic upper_i,
  output acc_e kind_o
);
  always_comb begin
    kind_o = ACC_IDLE;
    if (req_i) begin
      if (byte_i)    kind_o = ACC_BAD;
      else if (we_i) kind_o = upper_i ? ACC_WR_HI : ACC_WR_LO;
      else           kind_o = upper_i ? ACC_RD_HI : ACC_RD_LO;
    end
  end
endmodule

// File: rtl/hwb_hold.sv
module hwb_hold
  import hw_bridge_pkg::*;
#(
  parameter int HW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  acc_e          kind_i,
  input  logic [HW-1:0] wdata_i,
  input  logic [HW-1:0] rd_upper_i,
  output logic [HW-1:0] wlo_q_o,
  output logic [HW-1:0] rhi_q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wlo_q_o <= '0;
      rhi_q_o <= '0;
    end else begin
      if (kind_i == ACC_WR_LO) wlo_q_o <= wdata_i;
      if (kind_i == ACC_RD_LO) rhi_q_o <= rd_upper_i;
    end
  end
endmodule

// File: rtl/hwb_resp.sv
module hwb_resp
  import hw_bridge_pkg::*;
#(
  parameter int HW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  acc_e          kind_i,
  input  logic [HW-1:0] rd_lower_i,
  input  logic [HW-1:0] rhi_q_i,
  output logic [HW-1:0] rdata_o,
  output logic          ack_o,
  output logic          err_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_o <= '0;
      ack_o   <= 1'b0;
      err_o   <= 1'b0;
    end else begin
      ack_o <= (kind_i != ACC_IDLE) && (kind_i != ACC_BAD);
      err_o <= (kind_i == ACC_BAD);
      if (kind_i == ACC_RD_LO)      rdata_o <= rd_lower_i;
      else if (kind_i == ACC_RD_HI) rdata_o <= rhi_q_i; // latch from an earlier lower read
    end
  end
endmodule

// File: rtl/hw_word_bridge.sv
module hw_word_bridge
  import hw_bridge_pkg::*;
#(
  parameter int AW = 12,
  parameter int HW = 16
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            req_i,
  input  logic            we_i,
  input  logic            byte_i,
  input  logic [AW-1:0]   addr_i,
  input  logic [HW-1:0]   wdata_i,
  output logic [HW-1:0]   rdata_o,
  output logic            ack_o,
  output logic            err_o,
  output logic            reg_we_o,
  output logic            reg_re_o,
  output logic [AW-1:0]   reg_addr_o,
  output logic [2*HW-1:0] reg_wdata_o,
  input  logic [2*HW-1:0] reg_rdata_i
);
  localparam int DW   = 2 * HW;
  localparam int OFFB = $clog2(DW / 8);
  localparam int HSEL = OFFB - 1;

  acc_e          kind;
  logic [HW-1:0] wlo_q;
  logic [HW-1:0] rhi_q;

  hwb_decode u_decode (
    .req_i  (req_i),
    .we_i   (we_i),
    .byte_i (byte_i),
    .upper_i(addr_i[HSEL]),
    .kind_o (kind)
  );

  hwb_hold #(.HW(HW)) u_hold (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .kind_i    (kind),
    .wdata_i   (wdata_i),
    .rd_upper_i(reg_rdata_i[DW-1:HW]),
    .wlo_q_o   (wlo_q),
    .rhi_q_o   (rhi_q)
  );

  hwb_resp #(.HW(HW)) u_resp (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .kind_i    (kind),
    .rd_lower_i(reg_rdata_i[HW-1:0]),
    .rhi_q_i   (rhi_q),
    .rdata_o   (rdata_o),
    .ack_o     (ack_o),
    .err_o     (err_o)
  );

  assign reg_we_o    = (kind == ACC_WR_HI);
  assign reg_re_o    = (kind == ACC_RD_LO);
  assign reg_addr_o  = {addr_i[AW-1:OFFB], {OFFB{1'b0}}};
  assign reg_wdata_o = {wdata_i, wlo_q};
endmodule

// File: rtl/hw_word_bridge_chk.sv
module hw_word_bridge_chk #(
  parameter int AW = 12,
  parameter int HW = 16
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            req_i,
  input logic            we_i,
  input logic            byte_i,
  input logic [AW-1:0]   addr_i,
  input logic [HW-1:0]   wdata_i,
  input logic [HW-1:0]   rdata_o,
  input logic            ack_o,
  input logic            err_o,
  input logic            reg_we_o,
  input logic            reg_re_o,
  input logic [AW-1:0]   reg_addr_o,
  input logic [2*HW-1:0] reg_wdata_o,
  input logic [2*HW-1:0] reg_rdata_i
);
  logic half_ok;
  assign half_ok = req_i && !byte_i;

  // R2
  lo_write_silent_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    half_ok && we_i && !addr_i[1] |-> !reg_we_o && !reg_re_o);

  // R3
  hi_write_commit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    half_ok && we_i && addr_i[1] |-> reg_we_o && reg_wdata_o[2*HW-1:HW] == wdata_i);

  // R3
  word_addr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_we_o || reg_re_o |-> reg_addr_o[1:0] == 2'b00);

  // R4
  lo_read_data_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    half_ok && !we_i && !addr_i[1] |=> rdata_o == $past(reg_rdata_i[HW-1:0]));

  // R5
  hi_read_local_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    half_ok && !we_i && addr_i[1] |-> !reg_re_o && !reg_we_o);

  // R6
  byte_refused_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i && byte_i |-> !reg_we_o && !reg_re_o);

  // R6
  byte_err_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i && byte_i |=> err_o && !ack_o);

  // R6
  err_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> $past(req_i && byte_i));

  // R9
  ack_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    half_ok |=> ack_o && !err_o);

  // R9
  ack_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |-> $past(half_ok));

  // R9
  write_keeps_rdata_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i && we_i |=> $stable(rdata_o));
endmodule

bind hw_word_bridge hw_word_bridge_chk #(.AW(AW), .HW(HW)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .req_i      (req_i),
  .we_i       (we_i),
  .byte_i     (byte_i),
  .addr_i     (addr_i),
  .wdata_i    (wdata_i),
  .rdata_o    (rdata_o),
  .ack_o      (ack_o),
  .err_o      (err_o),
  .reg_we_o   (reg_we_o),
  .reg_re_o   (reg_re_o),
  .reg_addr_o (reg_addr_o),
  .reg_wdata_o(reg_wdata_o),
  .reg_rdata_i(reg_rdata_i)
);

// File: tb/tb_hw_word_bridge.sv
module tb_hw_word_bridge;
  localparam int AW = 12;
  localparam int HW = 16;

  logic            clk = 1'b0;
  logic            rst_ni = 1'b0;
  logic            req_i = 1'b0, we_i = 1'b0, byte_i = 1'b0;
  logic [AW-1:0]   addr_i = '0;
  logic [HW-1:0]   wdata_i = '0;
  logic [HW-1:0]   rdata_o;
  logic            ack_o, err_o, reg_we_o, reg_re_o;
  logic [AW-1:0]   reg_addr_o;
  logic [2*HW-1:0] reg_wdata_o, reg_rdata_i;
  logic [31:0]     mem [4];

  int total = 0, bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  hw_word_bridge #(.AW(AW), .HW(HW)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .req_i(req_i), .we_i(we_i), .byte_i(byte_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o), .ack_o(ack_o),
    .err_o(err_o), .reg_we_o(reg_we_o), .reg_re_o(reg_re_o),
    .reg_addr_o(reg_addr_o), .reg_wdata_o(reg_wdata_o), .reg_rdata_i(reg_rdata_i)
  );

  // downstream register bank model: four words
  assign reg_rdata_i = mem[reg_addr_o[3:2]];
  always @(posedge clk) if (reg_we_o) mem[reg_addr_o[3:2]] <= reg_wdata_o;

  typedef struct packed {
    logic        we;
    logic        byt;
    logic [3:0]  addr;
    logic [15:0] wdata;
    logic        e_dwe;
    logic        e_dre;
    logic        e_ack;
    logic        e_err;
    logic [31:0] e_wdata;
    logic [15:0] e_rd;
    logic        chk_rd;
    int          rq;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t TBL [NV] = '{
    '{0,0,4'h2,16'h0000, 0,0,1,0, 32'h0,        16'h0000,1, 1}, // R1 latch zero, R5
    '{1,0,4'h4,16'h1234, 0,0,1,0, 32'h0,        16'h0000,0, 2}, // R2
    '{1,0,4'h6,16'hABCD, 1,0,1,0, 32'hABCD1234, 16'h0000,0, 3}, // R3
    '{1,0,4'hA,16'h5555, 1,0,1,0, 32'h55551234, 16'h0000,0, 7}, // R7 held reused
    '{0,0,4'h4,16'h0000, 0,1,1,0, 32'h0,        16'h1234,1, 4}, // R4
    '{1,0,4'h8,16'h9999, 0,0,1,0, 32'h0,        16'h0000,0, 2}, // R2
    '{0,0,4'h6,16'h0000, 0,0,1,0, 32'h0,        16'hABCD,1, 5}, // R5
    '{1,1,4'h8,16'h00EE, 0,0,0,1, 32'h0,        16'h0000,0, 6}, // R6 byte write
    '{1,0,4'hA,16'h7777, 1,0,1,0, 32'h77779999, 16'h0000,0, 6}, // R6 hold untouched
    '{0,0,4'h2,16'h0000, 0,0,1,0, 32'h0,        16'hABCD,1, 8}, // R8 latch kept
    '{0,0,4'h8,16'h0000, 0,1,1,0, 32'h0,        16'h9999,1, 4}, // R4
    '{0,0,4'hA,16'h0000, 0,0,1,0, 32'h0,        16'h7777,1, 5}, // R5
    '{0,1,4'h0,16'h0000, 0,0,0,1, 32'h0,        16'h0000,0, 6}, // R6 byte read
    '{0,0,4'h4,16'h0000, 0,1,1,0, 32'h0,        16'h1234,1, 9}, // R9 err single cycle
    '{0,0,4'h6,16'h0000, 0,0,1,0, 32'h0,        16'hABCD,1, 6}  // R6 latch untouched
  };

  task automatic chk(input string what, input int rq, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL R%0d %s: actual=%h expected=%h", rq, what, act, exp);
    end
  endtask

  task automatic drive(input vec_t v);
    req_i = 1'b1; we_i = v.we; byte_i = v.byt;
    addr_i = {{(AW-4){1'b0}}, v.addr}; wdata_i = v.wdata;
  endtask

  task automatic idle();
    req_i = 1'b0; we_i = 1'b0; byte_i = 1'b0; addr_i = '0; wdata_i = '0;
  endtask

  task automatic check_strobes(input vec_t v);
    chk("reg_we_o", v.rq, 32'(reg_we_o), 32'(v.e_dwe));
    chk("reg_re_o", v.rq, 32'(reg_re_o), 32'(v.e_dre));
    if (v.e_dwe) chk("reg_wdata_o", v.rq, reg_wdata_o, v.e_wdata);
    if (v.e_dwe || v.e_dre) chk("reg_addr_o", v.rq, 32'(reg_addr_o), 32'(v.addr & 4'hC));
  endtask

  task automatic check_resp(input vec_t v);
    chk("ack_o", v.rq, 32'(ack_o), 32'(v.e_ack));
    chk("err_o", v.rq, 32'(err_o), 32'(v.e_err));
    if (v.chk_rd) chk("rdata_o", v.rq, 32'(rdata_o), 32'(v.e_rd));
  endtask

  initial begin
    for (int i = 0; i < 4; i++) mem[i] = 32'h0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("ack_o in reset", 1, 32'(ack_o), 0);
    chk("err_o in reset", 1, 32'(err_o), 0);
    chk("rdata_o in reset", 1, 32'(rdata_o), 0);
    chk("strobes in reset", 1, 32'({reg_we_o, reg_re_o}), 0);
    rst_ni = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      if (i > 0) check_resp(TBL[i-1]);
      drive(TBL[i]);
      #1;
      check_strobes(TBL[i]);
      @(negedge clk);
    end
    check_resp(TBL[NV-1]);
    idle();
    @(negedge clk);
    chk("ack_o after idle", 9, 32'(ack_o), 0);       // R9 single pulse
    chk("err_o after idle", 6, 32'(err_o), 0);

    // R1: reset clears held lower half and read latch
    drive('{1,0,4'h4,16'hBEEF, 0,0,1,0, 32'h0,16'h0,0, 1});
    @(negedge clk);
    idle();
    rst_ni = 1'b0;
    @(negedge clk);
    chk("ack_o during reset", 1, 32'(ack_o), 0);
    rst_ni = 1'b1;
    @(negedge clk);
    drive('{1,0,4'h6,16'h0001, 1,0,1,0, 32'h0,16'h0,0, 1});
    #1;
    chk("reg_wdata_o after reset", 1, reg_wdata_o, 32'h00010000);
    @(negedge clk);
    drive('{0,0,4'h6,16'h0000, 0,0,1,0, 32'h0,16'h0,1, 1});
    @(negedge clk);
    chk("rdata_o latch after reset", 1, 32'(rdata_o), 0);
    chk("ack_o upper read", 5, 32'(ack_o), 1);
    idle();
    @(negedge clk);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule